// File: doc/BRIEF.md
# Configurable Macrocell Register

This block is one output cell of a programmable-logic array. Its storage is a single D flip-flop with an asynchronous clear. Excitation logic in front of the flip-flop's data input makes the cell act as a plain D register, a JK register or an RS register. Static configuration inputs choose that behaviour.

An asynchronous set can be asked for even though the flip-flop only has a clear. In that case the cell stores the complement of its logical value, and a matching inverter on the read side restores true polarity. Driving the clear input then shows up as a set at the outputs.

A tristate buffer drives the bidirectional pin from the register. Its enable comes from a configurable source. The level on the pin is always returned as a feedback signal, so the pin doubles as an input when the cell does not drive it. When the cell is built without a pin, it acts as a buried node: it never drives the pin, and its feedback is its own register value.

Top module: `mcell_reg`

## Requirements
- R1: While `rst_n` is low, the stored bit is cleared. `q_out` reads 0 when set emulation is off and 1 when `cfg_aset_en` is 1 (legal configuration).
- R2: With `cfg_kind` = 0 (D type), each rising clock edge loads `in_a` into `q_out`.
- R3: With `cfg_kind` = 1 (JK type), `in_a` is J and `in_b` is K. On each rising edge the next `q_out` = J·!Q + !K·Q: hold on 00, clear on 01, set on 10, toggle on 11.
- R4: With `cfg_kind` = 2 (RS type), `in_a` is S and `in_b` is R. When they are not both high, the next `q_out` = S + !R·Q.
- R5: In RS type with S and R both high, `rs_conflict` is 1 and `q_out` keeps its value across the edge. Otherwise `rs_conflict` is 0.
- R6: With `cfg_aclr_en`=1 and `cfg_aset_en`=0, a high `async_ctl` forces `q_out` to 0 at once, with no clock edge needed. It stays 0 through clock edges while `async_ctl` is held. The first rising edge after release resumes normal loading.
- R7: With `cfg_aset_en`=1 and `cfg_aclr_en`=0, a high `async_ctl` forces `q_out` to 1 at once. In this inverted-storage configuration, the D, JK and RS types give the same true-polarity results as in R2–R4.
- R8: `cfg_illegal` is 1 when both asynchronous enables are set, or when `cfg_kind` = 3. With both enables set, `async_ctl` has no effect, storage is not inverted, and the clocked types still work. With `cfg_kind` = 3, the register holds its value.
- R9: `cfg_oe_sel` picks the pin enable: 0 never drives, 1 always drives `q_out`, 2 drives when `oe_in` is 1, and 3 drives when `oe_in` is 0.
- R10: `pin_fb` always equals the level on `pin`. When the cell does not drive the pin, it reports the value placed there by an external driver.
- R11: With parameter `HAS_PIN` = 0, the cell never drives `pin` and `pin_fb` equals `q_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the stored bit |
| cfg_kind | input | 2 | Register type: 0 D, 1 JK, 2 RS, 3 illegal |
| cfg_aset_en | input | 1 | Configure `async_ctl` as an asynchronous set |
| cfg_aclr_en | input | 1 | Configure `async_ctl` as an asynchronous clear |
| cfg_oe_sel | input | 2 | Pin enable source: 0 off, 1 on, 2 `oe_in`, 3 inverted `oe_in` |
| in_a | input | 1 | D, J or S input depending on type |
| in_b | input | 1 | K or R input depending on type |
| async_ctl | input | 1 | Asynchronous set/clear request, active high |
| oe_in | input | 1 | Dynamic output-enable input |
| pin | inout | 1 | Bidirectional device pin |
| q_out | output | 1 | Register value in true polarity |
| pin_fb | output | 1 | Level observed on the pin (or `q_out` for a buried node) |
| cfg_illegal | output | 1 | Configuration is not allowed |
| rs_conflict | output | 1 | RS type with S and R both high |

## Verification
The clocked function is swept over every combination of register type, storage polarity, prior register value and the two data inputs. This separates the hold, clear, set and toggle cases of each type, and shows that inverted storage leaves true-polarity behaviour unchanged. The asynchronous paths are exercised with clock edges arriving while the request is held. That distinguishes a true asynchronous override from a synchronous one, and a configuration with both asynchronous enables shows that the request is ignored. The pin is driven from outside against each enable source, which tells internal drive apart from external feedback. A buried-node instance has its pin driven opposite to its register value.

// File: rtl/mcell_pkg.sv
package mcell_pkg;
  typedef enum logic [1:0] {
    KIND_D   = 2'd0,
    KIND_JK  = 2'd1,
    KIND_RS  = 2'd2,
    KIND_BAD = 2'd3
  } reg_kind_e;

  typedef enum logic [1:0] {
    OE_OFF  = 2'd0,
    OE_ON   = 2'd1,
    OE_HIGH = 2'd2,
    OE_LOW  = 2'd3
  } oe_src_e;
endpackage

// File: rtl/mcell_excite.sv
module mcell_excite
  import mcell_pkg::*;
(
  input  reg_kind_e kind,
  input  logic      in_a,
  input  logic      in_b,
  input  logic      q_now,
  output logic      q_next,
  output logic      conflict
);
  always_comb begin
    conflict = 1'b0;
    unique case (kind)
      KIND_D:  q_next = in_a;
      KIND_JK: q_next = (in_a & ~q_now) | (~in_b & q_now);
      KIND_RS: begin
        conflict = in_a & in_b;
        q_next   = conflict ? q_now : (in_a | (~in_b & q_now));
      end
      default: q_next = q_now;
    endcase
  end
endmodule

// File: rtl/mcell_polarity.sv
module mcell_polarity (
  input  logic invert,
  input  logic stored,
  input  logic true_next,
  output logic true_now,
  output logic stored_next
);
  // Inverted storage makes the clear input of the flop act as a set at the
  // true-polarity side; for JK this is equivalent to swapping J and K.
  assign true_now    = stored ^ invert;
  assign stored_next = true_next ^ invert;
endmodule

// File: rtl/mcell_pinbuf.sv
module mcell_pinbuf
  import mcell_pkg::*;
#(
  parameter bit HAS_PIN = 1'b1
) (
  input  oe_src_e oe_sel,
  input  logic    oe_in,
  input  logic    q_true,
  inout  wire     pin,
  output logic    pin_fb
);
  logic drive;

  always_comb begin
    unique case (oe_sel)
      OE_OFF:  drive = 1'b0;
      OE_ON:   drive = 1'b1;
      OE_HIGH: drive = oe_in;
      default: drive = ~oe_in;
    endcase
  end

  generate
    if (HAS_PIN) begin : g_pad
      assign pin    = drive ? q_true : 1'bz;
      assign pin_fb = pin;
    end else begin : g_node
      assign pin    = 1'bz;
      assign pin_fb = q_true;
    end
  endgenerate
endmodule

// File: rtl/mcell_reg.sv
module mcell_reg
  import mcell_pkg::*;
#(
  parameter bit HAS_PIN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_kind,
  input  logic       cfg_aset_en,
  input  logic       cfg_aclr_en,
  input  logic [1:0] cfg_oe_sel,
  input  logic       in_a,
  input  logic       in_b,
  input  logic       async_ctl,
  input  logic       oe_in,
  inout  wire        pin,
  output logic       q_out,
  output logic       pin_fb,
  output logic       cfg_illegal,
  output logic       rs_conflict
);
  logic both_async;
  logic invert;
  logic async_go;
  logic arst;
  logic stored;
  logic stored_next;
  logic true_next;
  logic true_now;

  assign both_async  = cfg_aset_en & cfg_aclr_en;
  assign cfg_illegal = both_async | (reg_kind_e'(cfg_kind) == KIND_BAD);
  assign invert      = cfg_aset_en & ~both_async;
  assign async_go    = async_ctl & (cfg_aset_en ^ cfg_aclr_en);
  assign arst        = ~rst_n | async_go;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) stored <= 1'b0;
    else      stored <= stored_next;
  end

  mcell_polarity u_pol (
    .invert      (invert),
    .stored      (stored),
    .true_next   (true_next),
    .true_now    (true_now),
    .stored_next (stored_next)
  );

  mcell_excite u_exc (
    .kind     (reg_kind_e'(cfg_kind)),
    .in_a     (in_a),
    .in_b     (in_b),
    .q_now    (true_now),
    .q_next   (true_next),
    .conflict (rs_conflict)
  );

  mcell_pinbuf #(.HAS_PIN(HAS_PIN)) u_pad (
    .oe_sel (oe_src_e'(cfg_oe_sel)),
    .oe_in  (oe_in),
    .q_true (true_now),
    .pin    (pin),
    .pin_fb (pin_fb)
  );

  assign q_out = true_now;
endmodule

// File: rtl/mcell_reg_chk.sv
module mcell_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_kind,
  input logic       cfg_aset_en,
  input logic       cfg_aclr_en,
  input logic [1:0] cfg_oe_sel,
  input logic       in_a,
  input logic       in_b,
  input logic       async_ctl,
  input logic       q_out,
  input logic       pin_fb
);
  logic async_live;
  assign async_live = async_ctl & (cfg_aset_en ^ cfg_aclr_en);

  // R6
  p_async_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (async_ctl && cfg_aclr_en && !cfg_aset_en) |-> !q_out);

  // R7
  p_async_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (async_ctl && cfg_aset_en && !cfg_aclr_en) |-> q_out);

  // R2
  p_d_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_kind == 2'd0 && !async_live) |=>
      (!$stable(cfg_aset_en) || !$stable(cfg_aclr_en) || async_live ||
       q_out == $past(in_a)));

  // R5
  p_rs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_kind == 2'd2 && in_a && in_b && !async_live) |=>
      (!$stable(cfg_aset_en) || !$stable(cfg_aclr_en) || async_live ||
       q_out == $past(q_out)));

  // R9
  p_drive_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_oe_sel == 2'd1) |-> (pin_fb == q_out));
endmodule

bind mcell_reg mcell_reg_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_kind    (cfg_kind),
  .cfg_aset_en (cfg_aset_en),
  .cfg_aclr_en (cfg_aclr_en),
  .cfg_oe_sel  (cfg_oe_sel),
  .in_a        (in_a),
  .in_b        (in_b),
  .async_ctl   (async_ctl),
  .q_out       (q_out),
  .pin_fb      (pin_fb)
);

// File: tb/mcell_reg_tb.sv
`timescale 1ns/1ps
module mcell_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_kind = 2'd0;
  logic       cfg_aset_en = 1'b0;
  logic       cfg_aclr_en = 1'b0;
  logic [1:0] cfg_oe_sel = 2'd1;
  logic       in_a = 1'b0;
  logic       in_b = 1'b0;
  logic       async_ctl = 1'b0;
  logic       oe_in = 1'b0;
  logic       ext_oe = 1'b0;
  logic       ext_val = 1'b0;
  logic       node_ext = 1'b0;
  wire        pin;
  wire        node_pin;
  logic       q_out, pin_fb, cfg_illegal, rs_conflict;
  logic       nq, nfb, nill, nconf;
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  assign pin      = ext_oe ? ext_val : 1'bz;
  assign node_pin = node_ext;

  mcell_reg #(.HAS_PIN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_kind(cfg_kind), .cfg_aset_en(cfg_aset_en),
    .cfg_aclr_en(cfg_aclr_en), .cfg_oe_sel(cfg_oe_sel), .in_a(in_a), .in_b(in_b),
    .async_ctl(async_ctl), .oe_in(oe_in), .pin(pin), .q_out(q_out),
    .pin_fb(pin_fb), .cfg_illegal(cfg_illegal), .rs_conflict(rs_conflict));

  mcell_reg #(.HAS_PIN(1'b0)) u_node (
    .clk(clk), .rst_n(rst_n), .cfg_kind(cfg_kind), .cfg_aset_en(cfg_aset_en),
    .cfg_aclr_en(cfg_aclr_en), .cfg_oe_sel(cfg_oe_sel), .in_a(in_a), .in_b(in_b),
    .async_ctl(async_ctl), .oe_in(oe_in), .pin(node_pin), .q_out(nq),
    .pin_fb(nfb), .cfg_illegal(nill), .rs_conflict(nconf));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  function automatic logic model(input int kind, input logic a, input logic b,
                                 input logic q);
    case (kind)
      0: return a;
      1: return (a && !q) || (!b && q);
      2: return (a && b) ? q : (a || (!b && q));
      default: return q;
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state, plain polarity
    #3;
    check("R1 reset q", q_out, 1'b0);
    tick(); tick();
    rst_n = 1'b1;
    tick();

    // Sweep: R2 R3 R4 R5 R7 over polarity, type, prior value, inputs
    for (int inv = 0; inv < 2; inv++) begin
      cfg_aset_en = inv[0];
      for (int kind = 0; kind < 3; kind++) begin
        for (int q0 = 0; q0 < 2; q0++) begin
          for (int ab = 0; ab < 4; ab++) begin
            cfg_kind = 2'd0; in_a = q0[0]; in_b = 1'b0;
            tick();
            cfg_kind = kind[1:0]; in_a = ab[1]; in_b = ab[0];
            #1;
            if (kind == 2)
              check("R5 rs_conflict", rs_conflict, ab[1] & ab[0]);
            tick();
            if (kind == 0) check(inv ? "R7 D inverted" : "R2 D load", q_out,
                                 model(kind, ab[1], ab[0], q0[0]));
            else if (kind == 1) check(inv ? "R7 JK inverted" : "R3 JK", q_out,
                                 model(kind, ab[1], ab[0], q0[0]));
            else check(inv ? "R7 RS inverted" : "R4/R5 RS", q_out,
                       model(kind, ab[1], ab[0], q0[0]));
          end
        end
      end
    end

    // R1: reset with set emulation reads 1
    cfg_aset_en = 1'b1; cfg_kind = 2'd0; in_a = 1'b0;
    tick();
    rst_n = 1'b0;
    #1;
    check("R1 reset with set emulation", q_out, 1'b1);
    tick();
    rst_n = 1'b1;
    tick();

    // R6: async clear
    cfg_aset_en = 1'b0; cfg_aclr_en = 1'b1; in_a = 1'b1;
    tick();
    check("R6 preload", q_out, 1'b1);
    async_ctl = 1'b1;
    #1;
    check("R6 immediate clear", q_out, 1'b0);
    tick(); tick();
    check("R6 held through edges", q_out, 1'b0);
    #2;
    async_ctl = 1'b0;
    #1;
    check("R6 no change before edge", q_out, 1'b0);
    tick();
    check("R6 resume on edge", q_out, 1'b1);

    // R7: async set
    cfg_aclr_en = 1'b0; cfg_aset_en = 1'b1; in_a = 1'b0;
    tick();
    check("R7 preload", q_out, 1'b0);
    async_ctl = 1'b1;
    #1;
    check("R7 immediate set", q_out, 1'b1);
    tick();
    check("R7 held", q_out, 1'b1);
    #2;
    async_ctl = 1'b0;
    tick();
    check("R7 resume", q_out, 1'b0);

    // R8: both enables illegal, async ignored, no inversion
    cfg_aclr_en = 1'b1; in_a = 1'b1;
    #1;
    check("R8 illegal both", cfg_illegal, 1'b1);
    tick();
    check("R8 D still loads", q_out, 1'b1);
    async_ctl = 1'b1;
    #1;
    check("R8 async ignored", q_out, 1'b1);
    in_a = 1'b0;
    tick();
    check("R8 sync under async", q_out, 1'b0);
    async_ctl = 1'b0;
    cfg_aset_en = 1'b0; cfg_aclr_en = 1'b0;
    #1;
    check("R8 legal clears flag", cfg_illegal, 1'b0);
    cfg_kind = 2'd3; in_a = 1'b1; in_b = 1'b1;
    #1;
    check("R8 kind 3 illegal", cfg_illegal, 1'b1);
    tick();
    check("R8 kind 3 holds", q_out, 1'b0);

    // R9 / R10: pin enable sources and feedback
    cfg_kind = 2'd0; in_a = 1'b1;
    tick();
    cfg_oe_sel = 2'd1;
    #1;
    check("R9 always drive", pin_fb, q_out);
    cfg_oe_sel = 2'd0; ext_oe = 1'b1; ext_val = 1'b0;
    #1;
    check("R10 external low", pin_fb, 1'b0);
    ext_val = 1'b1; in_a = 1'b0;
    tick();
    check("R10 external high", pin_fb, 1'b1);
    ext_oe = 1'b0; cfg_oe_sel = 2'd2; oe_in = 1'b1;
    #1;
    check("R9 oe_in high drives", pin_fb, q_out);
    oe_in = 1'b0; ext_oe = 1'b1; ext_val = 1'b1;
    #1;
    check("R9 oe_in low releases", pin_fb, 1'b1);
    ext_oe = 1'b0; cfg_oe_sel = 2'd3; oe_in = 1'b0;
    #1;
    check("R9 inverted enable drives", pin_fb, q_out);
    oe_in = 1'b1; ext_oe = 1'b1; ext_val = ~q_out;
    #1;
    check("R9 inverted enable releases", pin_fb, ~q_out);
    ext_oe = 1'b0;

    // R11: buried node
    node_ext = ~nq;
    #1;
    check("R11 node fb is q", nfb, nq);
    in_a = 1'b1;
    tick();
    node_ext = ~nq;
    #1;
    check("R11 node fb follows q", nfb, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule